// File: doc/BRIEF.md
# DMA Channel Address Stepper

This block keeps the source and destination address registers of a single DMA channel and moves them forward, backward or not at all after every completed transfer. Software (or a control unit) loads either register through a simple write port; the transfer engine pulses a completion strobe once per transfer, and both registers then step together on the following clock edge. The direction of each side comes from its own 2-bit mode field. The step size comes from a 2-bit transfer-size code.

Two special cases change the step. In indirect mode the source register holds a pointer to the real data address, so it always moves by a whole 32-bit word, whatever the transfer size. In single-address transfers that carry data from an external device into the address space, both mode fields are disregarded and neither register changes. A mode field set to the prohibited code leaves its register untouched and raises a sticky error flag, which a register write clears.

Top module: `dma_addr_step`

## Requirements
- R1: After reset both addresses read 0 and the error flag reads 0.
- R2: With wr_en high, wr_data is loaded into the source register when wr_sel is 0 or into the destination register when wr_sel is 1, visible after that clock edge; the other register keeps its value.
- R3: In a cycle with neither wr_en nor xfer_done, both addresses and the error flag hold their values.
- R4: On a cycle with xfer_done high, each side updates at that clock edge according to its own mode field: 00 holds, 01 adds the step, 10 subtracts the step; the two sides are independent.
- R5: The step is 1 for size code 00 (byte), 2 for size code 01 (halfword) and 4 for size code 10 (word).
- R6: Size code 11 is reserved: a side that uses the size code does not move, and the error flag does not change.
- R7: Address arithmetic wraps modulo 2^32 in both directions.
- R8: Mode code 11 on a side leaves that address unchanged and sets the error flag, which then stays set through further transfers.
- R9: Any register write clears the error flag.
- R10: When single_mode and ext_to_mem are both high, a transfer-done strobe changes neither address and does not set the error flag, even with mode code 11.
- R11: With indirect high, the source register steps by exactly 4 (add for 01, subtract for 10, none for 00) for every size code including 11; the destination still follows the size code.
- R12: A register write in the same cycle as xfer_done takes priority: the written value is loaded, the other register holds, and no automatic step takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 source, 1 destination |
| wr_data | input | 32 | Write value |
| src_mode | input | 2 | Source direction: 00 hold, 01 up, 10 down, 11 prohibited |
| dst_mode | input | 2 | Destination direction, same coding |
| xfer_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| single_mode | input | 1 | Single-address transfer in progress |
| ext_to_mem | input | 1 | In single-address mode, data flows device to memory |
| indirect | input | 1 | Source register holds a pointer to the data address |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| mode_err | output | 1 | Sticky prohibited-mode flag |

## Verification
The properties assume that reset is held for at least one edge and that all control inputs are stable and known on every sampled edge; they make no assumption about how often xfer_done pulses. The stimulus changes every input on the falling edge only, keeps each strobe high for exactly one rising edge, and holds the mode, size and flag inputs steady across each pulse, so the value an assertion reads with $past is the value the design actually used.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_UP   = 2'b01,
    AM_DOWN = 2'b10,
    AM_BAD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSV  = 2'b11
  } xfer_size_e;

  localparam int STEP_W = 3;

  // Byte distance of one step; a pointer side always moves a full word.
  function automatic logic [STEP_W-1:0] step_amount(input logic [1:0] size,
                                                    input logic       word_forced);
    logic [STEP_W-1:0] amt;
    if (word_forced) begin
      amt = 3'd4;
    end else begin
      case (size)
        SZ_BYTE: amt = 3'd1;
        SZ_HALF: amt = 3'd2;
        SZ_WORD: amt = 3'd4;
        default: amt = 3'd0;
      endcase
    end
    return amt;
  endfunction

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic              word_forced,
  input  logic              ignore,
  output logic [ADDR_W-1:0] nxt,
  output logic              moves,
  output logic              illegal
);

  localparam int PAD_W = ADDR_W - STEP_W;

  logic [STEP_W-1:0] amt;
  logic [ADDR_W-1:0] amt_ext;
  logic              dir_up;
  logic              dir_down;

  always_comb begin
    amt      = step_amount(size, word_forced);
    amt_ext  = {{PAD_W{1'b0}}, amt};
    dir_up   = (mode == AM_UP);
    dir_down = (mode == AM_DOWN);
    illegal  = !ignore && (mode == AM_BAD);
    moves    = !ignore && (amt != '0) && (dir_up || dir_down);
    if (!moves)      nxt = cur;
    else if (dir_up) nxt = cur + amt_ext;
    else             nxt = cur - amt_ext;
  end

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic [ADDR_W-1:0] adv_val,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (adv)  q <= adv_val;
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic [1:0]        xfer_size,
  input  logic              single_mode,
  input  logic              ext_to_mem,
  input  logic              indirect,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              mode_err
);

  localparam int LANES    = 2;
  localparam int SRC_LANE = 0;
  localparam int DST_LANE = 1;

  logic [LANES-1:0][ADDR_W-1:0] cur_q;
  logic [LANES-1:0][ADDR_W-1:0] nxt_a;
  logic [LANES-1:0][1:0]        lane_mode;
  logic [LANES-1:0]             lane_word;
  logic [LANES-1:0]             lane_moves;
  logic [LANES-1:0]             lane_bad;
  logic [LANES-1:0]             lane_load;

  // Named events for the checker
  logic auto_ok;
  logic ext_ign;
  logic src_upd;
  logic dst_upd;
  logic bad_hit;

  assign ext_ign = single_mode && ext_to_mem;
  assign auto_ok = xfer_done && !wr_en;

  assign lane_mode[SRC_LANE] = src_mode;
  assign lane_mode[DST_LANE] = dst_mode;
  assign lane_word[SRC_LANE] = indirect;
  assign lane_word[DST_LANE] = 1'b0;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_load[g] = wr_en && (wr_sel == 1'(g));

      dma_step_calc #(.ADDR_W(ADDR_W)) u_calc (
        .cur        (cur_q[g]),
        .mode       (lane_mode[g]),
        .size       (xfer_size),
        .word_forced(lane_word[g]),
        .ignore     (ext_ign),
        .nxt        (nxt_a[g]),
        .moves      (lane_moves[g]),
        .illegal    (lane_bad[g])
      );

      dma_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lane_load[g]),
        .load_val(wr_data),
        .adv     (auto_ok && lane_moves[g]),
        .adv_val (nxt_a[g]),
        .q       (cur_q[g])
      );
    end
  endgenerate

  assign src_upd = auto_ok && lane_moves[SRC_LANE];
  assign dst_upd = auto_ok && lane_moves[DST_LANE];
  assign bad_hit = auto_ok && (|lane_bad);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_err <= 1'b0;
    else if (wr_en)   mode_err <= 1'b0;
    else if (bad_hit) mode_err <= 1'b1;
  end

  assign src_addr = cur_q[SRC_LANE];
  assign dst_addr = cur_q[DST_LANE];

endmodule

// File: rtl/dma_addr_step_chk.sv
module dma_addr_step_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [ADDR_W-1:0] wr_data,
  input logic [1:0]        src_mode,
  input logic [1:0]        xfer_size,
  input logic              indirect,
  input logic              xfer_done,
  input logic              ext_ign,
  input logic              src_upd,
  input logic              dst_upd,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              mode_err
);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !xfer_done) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(mode_err)));

  // R2
  src_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (src_addr == $past(wr_data) && $stable(dst_addr)));

  // R2
  dst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (dst_addr == $past(wr_data) && $stable(src_addr)));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !mode_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !wr_en) |=> mode_err);

  // R8
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_en && !ext_ign && src_mode == 2'b11) |=> ($stable(src_addr) && mode_err));

  // R10
  ext_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_en && ext_ign) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(mode_err)));

  // R11
  ptr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_en && !ext_ign && indirect && src_mode == 2'b01)
      |=> (src_addr == $past(src_addr) + ADDR_W'(4)));

  // R6
  rsv_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_size == 2'b11 && !indirect) |-> !src_upd && !dst_upd);

  // R12
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !src_upd && !dst_upd);

endmodule

bind dma_addr_step dma_addr_step_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .src_mode (src_mode),
  .xfer_size(xfer_size),
  .indirect (indirect),
  .xfer_done(xfer_done),
  .ext_ign  (ext_ign),
  .src_upd  (src_upd),
  .dst_upd  (dst_upd),
  .src_addr (src_addr),
  .dst_addr (dst_addr),
  .mode_err (mode_err)
);

// File: tb/sim_dma_addr_step.sv
`timescale 1ns/1ps
module sim_dma_addr_step;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  src_mode = 2'b00;
  logic [1:0]  dst_mode = 2'b00;
  logic [1:0]  xfer_size = 2'b00;
  logic        single_mode = 1'b0;
  logic        ext_to_mem = 1'b0;
  logic        indirect = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] src_addr;
  logic [31:0] dst_addr;
  logic        mode_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_addr_step u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_mode(src_mode), .dst_mode(dst_mode), .xfer_size(xfer_size),
    .single_mode(single_mode), .ext_to_mem(ext_to_mem), .indirect(indirect),
    .xfer_done(xfer_done), .src_addr(src_addr), .dst_addr(dst_addr), .mode_err(mode_err)
  );

  // Independent expectation: distance is 2^size bytes, pointer side fixed at 4.
  function automatic logic [31:0] expect_addr(input logic [31:0] a, input logic [1:0] m,
                                              input logic [1:0] sz, input bit ptr);
    int unsigned d;
    d = ptr ? 4 : ((sz == 2'b11) ? 0 : (32'd1 << sz));
    if (m == 2'b01) return a + d;
    if (m == 2'b10) return a - d;
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire();
    xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 src", src_addr, 32'h0);
    chk("R1 dst", dst_addr, 32'h0);
    chk("R1 err", {31'b0, mode_err}, 32'h0);
  endtask

  task automatic t_write_hold();
    wr(1'b0, 32'h0000_1000);
    chk("R2 src load", src_addr, 32'h0000_1000);
    chk("R2 dst kept", dst_addr, 32'h0);
    wr(1'b1, 32'h0000_2000);
    chk("R2 dst load", dst_addr, 32'h0000_2000);
    chk("R2 src kept", src_addr, 32'h0000_1000);
    src_mode = 2'b01; dst_mode = 2'b10;
    repeat (3) @(negedge clk);
    chk("R3 src hold", src_addr, 32'h0000_1000);
    chk("R3 dst hold", dst_addr, 32'h0000_2000);
  endtask

  task automatic t_modes();
    for (int sm = 0; sm < 3; sm++) begin
      for (int dm = 0; dm < 3; dm++) begin
        for (int sz = 0; sz < 3; sz++) begin
          wr(1'b0, 32'h1000_0040);
          wr(1'b1, 32'h2000_0080);
          src_mode = 2'(sm); dst_mode = 2'(dm); xfer_size = 2'(sz);
          fire();
          chk("R4 R5 src", src_addr, expect_addr(32'h1000_0040, 2'(sm), 2'(sz), 1'b0));
          chk("R4 R5 dst", dst_addr, expect_addr(32'h2000_0080, 2'(dm), 2'(sz), 1'b0));
        end
      end
    end
  endtask

  task automatic t_rsv_size();
    wr(1'b0, 32'h0000_0100);
    wr(1'b1, 32'h0000_0200);
    src_mode = 2'b01; dst_mode = 2'b10; xfer_size = 2'b11;
    fire();
    chk("R6 src", src_addr, 32'h0000_0100);
    chk("R6 dst", dst_addr, 32'h0000_0200);
    chk("R6 err", {31'b0, mode_err}, 32'h0);
  endtask

  task automatic t_wrap();
    wr(1'b0, 32'hFFFF_FFFE);
    wr(1'b1, 32'h0000_0001);
    src_mode = 2'b01; dst_mode = 2'b10; xfer_size = 2'b10;
    fire();
    chk("R7 up wrap", src_addr, 32'h0000_0002);
    chk("R7 down wrap", dst_addr, 32'hFFFF_FFFD);
  endtask

  task automatic t_bad_mode();
    wr(1'b0, 32'h0000_0300);
    wr(1'b1, 32'h0000_0400);
    src_mode = 2'b11; dst_mode = 2'b01; xfer_size = 2'b01;
    fire();
    chk("R8 src held", src_addr, 32'h0000_0300);
    chk("R8 dst steps", dst_addr, 32'h0000_0402);
    chk("R8 err set", {31'b0, mode_err}, 32'h1);
    src_mode = 2'b01;
    fire();
    chk("R8 err sticky", {31'b0, mode_err}, 32'h1);
    chk("R8 src legal again", src_addr, 32'h0000_0302);
    wr(1'b1, 32'h0000_0500);
    chk("R9 err cleared", {31'b0, mode_err}, 32'h0);
  endtask

  task automatic t_single();
    wr(1'b0, 32'h0000_0600);
    wr(1'b1, 32'h0000_0700);
    single_mode = 1'b1; ext_to_mem = 1'b1;
    src_mode = 2'b01; dst_mode = 2'b11; xfer_size = 2'b10;
    fire();
    chk("R10 src", src_addr, 32'h0000_0600);
    chk("R10 dst", dst_addr, 32'h0000_0700);
    chk("R10 err", {31'b0, mode_err}, 32'h0);
    ext_to_mem = 1'b0; dst_mode = 2'b10;
    fire();
    chk("R10 other dir src", src_addr, 32'h0000_0604);
    chk("R10 other dir dst", dst_addr, 32'h0000_06FC);
    single_mode = 1'b0;
  endtask

  task automatic t_indirect();
    wr(1'b0, 32'h0000_0800);
    wr(1'b1, 32'h0000_0900);
    indirect = 1'b1; src_mode = 2'b01; dst_mode = 2'b01; xfer_size = 2'b00;
    fire();
    chk("R11 src +4 byte", src_addr, 32'h0000_0804);
    chk("R11 dst +1", dst_addr, 32'h0000_0901);
    xfer_size = 2'b11;
    fire();
    chk("R11 src +4 rsv", src_addr, 32'h0000_0808);
    chk("R11 dst rsv", dst_addr, 32'h0000_0901);
    src_mode = 2'b10; xfer_size = 2'b01;
    fire();
    chk("R11 src -4", src_addr, 32'h0000_0804);
    chk("R11 dst +2", dst_addr, 32'h0000_0903);
    indirect = 1'b0;
  endtask

  task automatic t_collide();
    wr(1'b0, 32'h0000_0A00);
    wr(1'b1, 32'h0000_0B00);
    src_mode = 2'b01; dst_mode = 2'b01; xfer_size = 2'b10;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0C00; xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; xfer_done = 1'b0;
    chk("R12 src written", src_addr, 32'h0000_0C00);
    chk("R12 dst no step", dst_addr, 32'h0000_0B00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_hold();
    t_modes();
    t_rsv_size();
    t_wrap();
    t_bad_mode();
    t_single();
    t_indirect();
    t_collide();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule